// File: doc/BRIEF.md
# Serial Flash Command Target

This block is the device side of a single-bit serial flash command port. A host frames each command by pulling chip select low. It then shifts in an 8-bit opcode, most significant bit first, and for the read command a 24-bit address. Write enable, write disable, two status reads, a status write and a plain data read are decoded. Read data come from a small internal pattern memory, and status bytes report a busy flag and a write-enable latch.

All serial pins are sampled by the system clock `clk`, which must run several times faster than the serial clock. Edges of `sck` and `cs_n` are detected by comparing each sample with the one before it. The hold input pauses a command in mid-stream. The active-low write-protect input can lock the status register. A quad-enable bit in the second status register releases both pins for use as data lines, and then neither the hold nor the protect function acts.

Top module: `sflash_target`

## Requirements
- R1: Opcode, address and write data bits are taken on rising edges of `sck`. `so` changes only after a falling edge of `sck`. The first output bit is presented after the falling edge that follows the last header bit.
- R2: While `cs_n` is high, `so_oe` is 0 from the next `clk` cycle on. It is also 0 after reset.
- R3: After reset, no command is accepted until `cs_n` has been seen going from high to low. A command clocked in while `cs_n` was already low at reset has no effect.
- R4: While `cs_n` is low, `hold_n` is low and QE is 0, `so_oe` is 0 from the next `clk` cycle and `sck` edges are ignored. When `hold_n` returns high, the transfer resumes at the bit where it stopped.
- R5: While QE (status register 2, bit 1) is 1, `hold_n` and `wp_n` have no effect.
- R6: Opcode 06h sets WEL and 04h clears it. Opcode 05h returns status register 1 = {bits 7:2 stored, WEL at bit 1, BUSY at bit 0}. Opcode 35h returns status register 2. Both repeat their byte for as long as the host keeps clocking.
- R7: Opcode 01h is ignored unless WEL is 1. When `cs_n` rises after exactly 8 data bits, the first byte's bits 7:2 go to status register 1. After exactly 16 bits, the second byte also goes to status register 2. On such a commit, WEL clears and BUSY reads 1 for BUSY_CYCLES `clk` cycles. Any other bit count writes nothing and leaves WEL set.
- R8: When status register 1 bit 7 is 1, `wp_n` is low and QE is 0, opcode 01h writes nothing and WEL stays 1.
- R9: While BUSY is 1, only 05h and 35h are accepted. Any other opcode, including 06h, is ignored for the rest of that frame.
- R10: Opcode 03h followed by a 24-bit address returns bytes starting at A = address mod 2^MEM_AW. The byte at A is the low 8 bits of A*7, XOR SEED. The address increments for each further byte and wraps from 2^MEM_AW-1 to 0.
- R11: An unknown opcode makes the block ignore all input until the next falling edge of `cs_n`. `so_oe` stays 0 for that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low status write protect (data line when QE=1) |
| hold_n | input | 1 | Active-low pause (data line when QE=1) |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
The bench builds the block with MEM_AW=6, which gives a 64-byte pattern memory. A read started at address 3Eh therefore reaches the wrap to zero within four bytes, and high address bits can be shown to be dropped. BUSY_CYCLES=1000 keeps BUSY high long enough for a whole write-enable frame, a status read and a refused read to fall inside one busy window. SEED=5Ah keeps every expected byte distinct from plain address values.

// File: rtl/sflash_target.sv
module sflash_target #(
  parameter int          MEM_AW      = 8,
  parameter int          BUSY_CYCLES = 64,
  parameter logic [7:0]  SEED        = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_OFF, S_OPC, S_ADDR, S_RDAT, S_STAT, S_WSR, S_SKIP} st_t;

  st_t               st;
  logic              sck_d, cs_d;
  logic [4:0]        cnt;
  logic [23:0]       sh;
  logic [MEM_AW-1:0] addr;
  logic              stat_sel;
  logic [7:0]        out_sr;
  logic [2:0]        out_cnt;
  logic              primed;
  logic              wel;
  logic [5:0]        sr1_hi;
  logic [7:0]        sr2;
  logic [BW-1:0]     busy_cnt;
  logic [4:0]        wbits;

  function automatic logic [7:0] pat(input logic [MEM_AW-1:0] a);
    logic [MEM_AW+7:0] p;
    p = {8'd0, a} * (MEM_AW+8)'(7);
    return p[7:0] ^ SEED;
  endfunction

  wire        qe       = sr2[1];
  wire        busy     = busy_cnt != '0;
  wire        hold_act = !cs_n && !hold_n && !qe;
  wire        rise     = sck && !sck_d && !hold_act;
  wire        fall     = !sck && sck_d && !hold_act;
  wire        cs_fall  = cs_d && !cs_n;
  wire        cs_rise  = !cs_d && cs_n;
  wire [23:0] shin     = {sh[22:0], si};
  wire [7:0]  sr1      = {sr1_hi, wel, busy};
  wire        wp_block = sr1_hi[5] && !wp_n && !qe;
  wire        wsr_ok   = wel && !wp_block && (wbits == 5'd8 || wbits == 5'd16);
  wire [7:0]  wsr_b1   = (wbits == 5'd16) ? sh[15:8] : sh[7:0];
  wire [7:0]  nb       = (st == S_RDAT) ? pat(addr) : (stat_sel ? sr2 : sr1);

  assign so = out_sr[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OFF; sck_d <= 1'b0; cs_d <= 1'b0; cnt <= '0; sh <= '0;
      addr <= '0; stat_sel <= 1'b0; out_sr <= '0; out_cnt <= '0;
      primed <= 1'b0; wel <= 1'b0; sr1_hi <= '0; sr2 <= '0;
      busy_cnt <= '0; wbits <= '0; so_oe <= 1'b0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      so_oe <= primed && !cs_n && !hold_act && (st == S_RDAT || st == S_STAT);
      if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (cs_n) begin
        st     <= S_OFF;
        primed <= 1'b0;
        if (cs_rise && st == S_WSR && wsr_ok) begin
          sr1_hi <= wsr_b1[7:2];
          if (wbits == 5'd16) sr2 <= sh[7:0];
          wel      <= 1'b0;
          busy_cnt <= BW'(BUSY_CYCLES);
        end
      end else if (cs_fall) begin
        st      <= S_OPC;
        cnt     <= '0;
        out_cnt <= '0;
        primed  <= 1'b0;
      end else begin
        case (st)
          S_OPC: if (rise) begin
            sh  <= shin;
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              if (busy && shin[7:0] != 8'h05 && shin[7:0] != 8'h35) st <= S_SKIP;
              else begin
                case (shin[7:0])
                  8'h06:   begin wel <= 1'b1; st <= S_SKIP; end
                  8'h04:   begin wel <= 1'b0; st <= S_SKIP; end
                  8'h05:   begin st <= S_STAT; stat_sel <= 1'b0; end
                  8'h35:   begin st <= S_STAT; stat_sel <= 1'b1; end
                  8'h01:   begin st <= S_WSR; wbits <= '0; end
                  8'h03:   begin st <= S_ADDR; cnt <= '0; end
                  default: st <= S_SKIP;
                endcase
              end
            end
          end
          S_ADDR: if (rise) begin
            sh  <= shin;
            cnt <= cnt + 5'd1;
            if (cnt == 5'd23) begin
              addr <= shin[MEM_AW-1:0];
              st   <= S_RDAT;
            end
          end
          S_RDAT, S_STAT: if (fall) begin
            out_cnt <= out_cnt + 3'd1;
            if (out_cnt == 3'd0) begin
              out_sr <= nb;
              primed <= 1'b1;
              if (st == S_RDAT) addr <= addr + 1'b1;
            end else begin
              out_sr <= {out_sr[6:0], 1'b0};
            end
          end
          S_WSR: if (rise) begin
            sh <= shin;
            if (wbits != 5'd17) wbits <= wbits + 5'd1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sflash_target_chk.sv
module sflash_target_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic sck,
  input logic sck_d,
  input logic so,
  input logic so_oe,
  input logic qe,
  input logic wel,
  input logic busy
);

  a_r1_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$stable(so)) |-> $past(sck_d && !sck));

  a_r2_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);

  a_r4_hold_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !hold_n && !qe) |=> !so_oe);

  a_r7_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && !wel));

  a_r9_no_wel_rise_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(wel));

endmodule

bind sflash_target sflash_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .sck(sck),
  .sck_d(sck_d), .so(so), .so_oe(so_oe), .qe(sr2[1]), .wel(wel), .busy(busy)
);

// File: tb/sflash_target_tb.sv
`timescale 1ns/1ps
module sflash_target_tb;
  localparam int         AW   = 6;
  localparam int         BUSY = 1000;
  localparam logic [7:0] SEED = 8'h5A;
  localparam int         HALF = 6;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 0, si = 0, wp_n = 1, hold_n = 1;
  logic so, so_oe;
  int   nchk = 0, nerr = 0, stable_err = 0;
  logic oe_acc = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  sflash_target #(.MEM_AW(AW), .BUSY_CYCLES(BUSY), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_oe(so_oe));

  function automatic logic [7:0] pat(input int a);
    int m = a % (1 << AW);
    return 8'((m * 7) & 8'hFF) ^ SEED;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [15:0] tx, output logic [15:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      si = tx[i];
      waitc(HALF);
      rx[i] = so;
      oe_acc |= so_oe;
      sck = 1;
      waitc(HALF);
      if (so_oe && so !== rx[i]) stable_err++;
      sck = 0;
    end
  endtask

  task automatic bx(input logic [7:0] tx, output logic [7:0] rx);
    logic [15:0] r;
    xfer(8, {8'h00, tx}, r);
    rx = r[7:0];
  endtask

  task automatic sel();
    cs_n = 0; waitc(HALF);
  endtask

  task automatic desel();
    waitc(HALF); cs_n = 1; waitc(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); bx(op, r); desel();
  endtask

  task automatic rd_sr(input logic [7:0] op, output logic [7:0] v);
    logic [7:0] r;
    sel(); bx(op, r); bx(8'h00, v); desel();
  endtask

  task automatic wsr(input int n, input logic [15:0] d);
    logic [7:0] r; logic [15:0] r16;
    sel(); bx(8'h01, r); xfer(n, d, r16); desel();
  endtask

  task automatic t_reset();
    logic [7:0] r, v;
    waitc(10); rst_n = 1; waitc(2);
    chk("R2 reset so_oe", {15'd0, so_oe}, 16'd0);
    bx(8'h06, r);
    cs_n = 1; waitc(2 * HALF);
    rd_sr(8'h05, v);
    chk("R3 no command before first cs fall", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_wel();
    logic [7:0] r, v1, v2;
    cmd1(8'h06);
    sel(); bx(8'h05, r); bx(8'h00, v1); bx(8'h00, v2); desel();
    chk("R6 WEL set, first status byte", {8'd0, v1}, 16'h0002);
    chk("R6 status repeats", {8'd0, v2}, 16'h0002);
    cmd1(8'h04);
    rd_sr(8'h05, v1);
    chk("R6 WEL cleared by 04h", {8'd0, v1}, 16'h0000);
    rd_sr(8'h35, v1);
    chk("R6 status register 2", {8'd0, v1}, 16'h0000);
  endtask

  task automatic t_read();
    logic [7:0] r, d;
    sel(); bx(8'h03, r); bx(8'h00, r); bx(8'h00, r); bx(8'h10, r);
    for (int k = 0; k < 4; k++) begin
      bx(8'h00, d);
      chk($sformatf("R10 read byte %0d at 10h", k), {8'd0, d}, {8'd0, pat(16 + k)});
    end
    desel();
    chk("R2 so_oe low after deselect", {15'd0, so_oe}, 16'd0);
    sel(); bx(8'h03, r); bx(8'hAB, r); bx(8'hCD, r); bx(8'h3E, r);
    for (int k = 0; k < 4; k++) begin
      bx(8'h00, d);
      chk($sformatf("R10 wrap byte %0d", k), {8'd0, d}, {8'd0, pat(62 + k)});
    end
    desel();
    chk("R1 so stable while sck high", stable_err[15:0], 16'd0);
  endtask

  task automatic t_wsr_busy();
    logic [7:0] r, v;
    wsr(16, 16'h3C00);
    rd_sr(8'h05, v);
    chk("R7 status write refused without WEL", {8'd0, v}, 16'h0000);
    cmd1(8'h06);
    wsr(16, 16'h3C00);
    cmd1(8'h06);
    rd_sr(8'h05, v);
    chk("R7 commit: WEL clear, BUSY set", {8'd0, v}, 16'h003D);
    oe_acc = 0;
    sel(); bx(8'h03, r); bx(8'h00, r); bx(8'h00, r); bx(8'h00, r); bx(8'h00, r); desel();
    chk("R9 read refused while busy", {15'd0, oe_acc}, 16'd0);
    waitc(BUSY + 100);
    rd_sr(8'h05, v);
    chk("R9 WREN ignored while busy", {8'd0, v}, 16'h003C);
    cmd1(8'h06);
    wsr(12, 16'h0000);
    rd_sr(8'h05, v);
    chk("R7 partial write ignored, WEL kept", {8'd0, v}, 16'h003E);
    wsr(8, 16'h0000);
    waitc(BUSY + 100);
    rd_sr(8'h05, v);
    chk("R7 single byte write", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_wp_qe();
    logic [7:0] v;
    cmd1(8'h06); wsr(8, 16'h0080); waitc(BUSY + 100);
    rd_sr(8'h05, v);
    chk("R7 protect bit stored", {8'd0, v}, 16'h0080);
    wp_n = 0;
    cmd1(8'h06); wsr(8, 16'h0000);
    rd_sr(8'h05, v);
    chk("R8 write blocked by wp_n", {8'd0, v}, 16'h0082);
    wp_n = 1;
    wsr(16, 16'h8002); waitc(BUSY + 100);
    rd_sr(8'h35, v);
    chk("R7 status register 2 written", {8'd0, v}, 16'h0002);
    wp_n = 0; hold_n = 0;
    cmd1(8'h06);
    oe_acc = 0;
    rd_sr(8'h05, v);
    chk("R5 hold ignored with QE, data", {8'd0, v}, 16'h0082);
    chk("R5 hold ignored with QE, so_oe", {15'd0, oe_acc}, 16'd1);
    wsr(16, 16'h0002); waitc(BUSY + 100);
    rd_sr(8'h05, v);
    chk("R5 wp_n ignored with QE", {8'd0, v}, 16'h0000);
    cmd1(8'h06); wsr(16, 16'h0000); waitc(BUSY + 100);
    hold_n = 1; wp_n = 1;
    rd_sr(8'h35, v);
    chk("R7 QE cleared", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_hold();
    logic [7:0] r, d;
    sel(); bx(8'h03, r); bx(8'h00, r); bx(8'h00, r); bx(8'h05, r);
    bx(8'h00, d);
    chk("R10 byte before hold", {8'd0, d}, {8'd0, pat(5)});
    waitc(2);
    hold_n = 0; waitc(HALF);
    chk("R4 so_oe low during hold", {15'd0, so_oe}, 16'd0);
    for (int k = 0; k < 3; k++) begin
      sck = 1; waitc(HALF); sck = 0; waitc(HALF);
    end
    hold_n = 1; waitc(HALF);
    bx(8'h00, d);
    chk("R4 resume after hold", {8'd0, d}, {8'd0, pat(6)});
    desel();
  endtask

  task automatic t_unknown();
    logic [7:0] r, v;
    oe_acc = 0;
    sel(); bx(8'hA7, r); bx(8'h06, r); bx(8'h00, r); desel();
    chk("R11 so_oe low after unknown opcode", {15'd0, oe_acc}, 16'd0);
    rd_sr(8'h05, v);
    chk("R11 rest of frame ignored", {8'd0, v}, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_wel();
    t_read();
    t_wsr_busy();
    t_wp_qe();
    t_hold();
    t_unknown();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule